// File: doc/BRIEF.md
# PCIe Reference Clock Bring-Up Sequencer

This block powers up one PCIe port in a fixed, timed order. A one-cycle prepare pulse starts a run. The run holds the endpoint reset pins low and the reference clock off. It then turns the reference clock on and pulses the controller reset group. Last, it releases the endpoint resets. Every step is followed by a settle window. When the last window has elapsed, the block raises a done flag.

A one-cycle unprepare pulse turns the reference clock off. On a finished or idle block it changes nothing else. During a run it also abandons the sequence. Each window is a cycle count derived from a clock-period parameter and a time in microseconds. Real silicon uses the millisecond defaults, and a bench can use much shorter windows.

Top module: `pcie_refclk_seq`

## Requirements
- R1: After reset all outputs are low: `refclk_en`=0, `clk_on`=0, `dev_rst_n`=2'b00, `ctrl_rst`=3'b000, `busy`=0 and `done`=0.
- R2: A prepare pulse accepted while not busy raises `busy` on the next edge. From that edge, `dev_rst_n` is 2'b00 and `refclk_en` is 0 for N_SETTLE cycles, even if the clock was on before.
- R3: `refclk_en` rises exactly N_SETTLE cycles after `busy` rises, while `dev_rst_n` is still 2'b00.
- R4: The three `ctrl_rst` bits always carry the same value. Bit 0 is the host bridge, bit 1 is port 1 and bit 2 is port 2. The group is driven to 0 at 2*N_SETTLE cycles after `busy` rises. It is driven to 3'b111 at 3*N_SETTLE cycles and back to 0 at 3*N_SETTLE+N_PULSE cycles.
- R5: `dev_rst_n` stays 2'b00 until 4*N_SETTLE+N_PULSE+N_RECOVER cycles after `busy` rises, and then both bits go high together.
- R6: `done` rises and `busy` falls together, N_RELEASE cycles after the endpoint reset release. At that point `dev_rst_n`=2'b11, `refclk_en`=1 and `ctrl_rst`=0.
- R7: An unprepare pulse while not busy clears `refclk_en` and `done` on the next edge. It leaves `dev_rst_n` and `ctrl_rst` unchanged.
- R8: `clk_on` always equals `refclk_en`.
- R9: A prepare pulse while busy is ignored, and the running timeline is not altered.
- R10: An unprepare pulse while busy ends the run on the next edge. At that edge `busy`=0, `done`=0 and `refclk_en`=0, and `dev_rst_n` and `ctrl_rst` keep their values.
- R11: When prepare and unprepare arrive in the same cycle, unprepare wins and no run starts.
- R12: Each window length in cycles is ceil(us*1000/CLK_PERIOD_NS), with a minimum of 1. N_SETTLE, N_PULSE, N_RECOVER and N_RELEASE come from SETTLE_US, PULSE_US, RECOVER_US and RELEASE_US.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prepare_req | input | 1 | One-cycle request to run the bring-up sequence |
| unprepare_req | input | 1 | One-cycle request to gate the reference clock off |
| dev_rst_n | output | 2 | Endpoint reset pins, active low |
| refclk_en | output | 1 | Reference clock enable |
| ctrl_rst | output | 3 | Controller reset group (host bridge, port 1, port 2) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed and not since unprepared |
| clk_on | output | 1 | Clock-enabled status |

## Verification
Full runs are started from three different states:
- From reset, with everything low.
- From a finished run, with the clock on and the endpoints released. This shows that the first step actively forces the clock off and the endpoint resets low.
- From an aborted run that left the reset group asserted. This shows the reset group being driven low in its own step.

Each transition is sampled on the cycle before and the cycle of the expected edge, so an off-by-one window is caught. Other patterns are a prepare pulse injected mid-run, an unprepare during the reset pulse, an unprepare on an idle block, and coincident requests. Each of these separates "ignored" from "restarted" or "fully cleared".

// File: rtl/refclk_seq_pkg.sv
package refclk_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE       = 3'd0,
        PH_PERST_LOW  = 3'd1,
        PH_CLK_ON     = 3'd2,
        PH_RST_PRE    = 3'd3,
        PH_RST_PULSE  = 3'd4,
        PH_RST_POST   = 3'd5,
        PH_PERST_HOLD = 3'd6,
        PH_PERST_REL  = 3'd7
    } phase_e;

    // Output changes applied on entry to a phase.
    typedef struct packed {
        logic set_perst;
        logic perst_val;
        logic set_ref;
        logic ref_val;
        logic set_grp;
        logic grp_val;
    } phase_act_t;

    typedef struct packed {
        phase_e     phase;
        logic [1:0] dev_rst_n;
        logic       refclk_en;
        logic [2:0] ctrl_rst;
        logic       done;
    } seq_state_t;

    function automatic int unsigned us_to_cyc(int unsigned us, int unsigned period_ns);
        longint unsigned ns;
        longint unsigned c;
        ns = longint'(us) * 64'd1000;
        c  = (ns + longint'(period_ns) - 64'd1) / longint'(period_ns);
        if (c == 64'd0) c = 64'd1;
        return 32'(c);
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refclk_delay_timer.sv
module refclk_delay_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/refclk_phase_table.sv
module refclk_phase_table
    import refclk_seq_pkg::*;
#(
    parameter int          CW        = 8,
    parameter int unsigned N_SETTLE  = 2,
    parameter int unsigned N_PULSE   = 2,
    parameter int unsigned N_RECOVER = 2,
    parameter int unsigned N_RELEASE = 2
) (
    input  phase_e        ph,
    output phase_act_t    act,
    output logic [CW-1:0] load_val
);
    localparam logic [CW-1:0] L_SETTLE  = CW'(N_SETTLE - 1);
    localparam logic [CW-1:0] L_PULSE   = CW'(N_PULSE - 1);
    localparam logic [CW-1:0] L_RECOVER = CW'(N_RECOVER - 1);
    localparam logic [CW-1:0] L_RELEASE = CW'(N_RELEASE - 1);

    always_comb begin
        act      = '0;
        load_val = L_SETTLE;
        unique case (ph)
            PH_PERST_LOW: begin
                act.set_perst = 1'b1; act.perst_val = 1'b0;
                act.set_ref   = 1'b1; act.ref_val   = 1'b0;
            end
            PH_CLK_ON: begin
                act.set_ref = 1'b1; act.ref_val = 1'b1;
            end
            PH_RST_PRE: begin
                act.set_grp = 1'b1; act.grp_val = 1'b0;
            end
            PH_RST_PULSE: begin
                act.set_grp = 1'b1; act.grp_val = 1'b1;
                load_val    = L_PULSE;
            end
            PH_RST_POST: begin
                act.set_grp = 1'b1; act.grp_val = 1'b0;
                load_val    = L_RECOVER;
            end
            PH_PERST_HOLD: begin
                act.set_perst = 1'b1; act.perst_val = 1'b0;
            end
            PH_PERST_REL: begin
                act.set_perst = 1'b1; act.perst_val = 1'b1;
                load_val      = L_RELEASE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pcie_refclk_seq.sv
module pcie_refclk_seq
    import refclk_seq_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned SETTLE_US     = 1000,
    parameter int unsigned PULSE_US      = 100000,
    parameter int unsigned RECOVER_US    = 5000,
    parameter int unsigned RELEASE_US    = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prepare_req,
    input  logic       unprepare_req,
    output logic [1:0] dev_rst_n,
    output logic       refclk_en,
    output logic [2:0] ctrl_rst,
    output logic       busy,
    output logic       done,
    output logic       clk_on
);
    localparam int unsigned N_SETTLE  = us_to_cyc(SETTLE_US, CLK_PERIOD_NS);
    localparam int unsigned N_PULSE   = us_to_cyc(PULSE_US, CLK_PERIOD_NS);
    localparam int unsigned N_RECOVER = us_to_cyc(RECOVER_US, CLK_PERIOD_NS);
    localparam int unsigned N_RELEASE = us_to_cyc(RELEASE_US, CLK_PERIOD_NS);
    localparam int unsigned N_MAX     = max2(max2(N_SETTLE, N_PULSE), max2(N_RECOVER, N_RELEASE));
    localparam int          CW        = (N_MAX > 1) ? $clog2(N_MAX) : 1;

    seq_state_t    s_d, s_q;
    phase_e        target;
    phase_act_t    act;
    logic [CW-1:0] load_val;
    logic          load;
    logic          expired;

    // Phase that would be entered next.
    always_comb begin
        if (s_q.phase == PH_IDLE) target = PH_PERST_LOW;
        else                      target = phase_e'(s_q.phase + 3'd1);
    end

    refclk_phase_table #(
        .CW(CW), .N_SETTLE(N_SETTLE), .N_PULSE(N_PULSE),
        .N_RECOVER(N_RECOVER), .N_RELEASE(N_RELEASE)
    ) u_table (
        .ph(target), .act(act), .load_val(load_val)
    );

    refclk_delay_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load),
        .load_val(load_val), .expired(expired)
    );

    always_comb begin
        logic enter;
        s_d   = s_q;
        enter = 1'b0;
        if (unprepare_req) begin
            s_d.phase     = PH_IDLE;
            s_d.refclk_en = 1'b0;
            s_d.done      = 1'b0;
        end else if (s_q.phase == PH_IDLE) begin
            if (prepare_req) begin
                enter    = 1'b1;
                s_d.done = 1'b0;
            end
        end else if (expired) begin
            if (s_q.phase == PH_PERST_REL) begin
                s_d.phase = PH_IDLE;
                s_d.done  = 1'b1;
            end else begin
                enter = 1'b1;
            end
        end
        if (enter) begin
            s_d.phase = target;
            if (act.set_perst) s_d.dev_rst_n = {2{act.perst_val}};
            if (act.set_ref)   s_d.refclk_en = act.ref_val;
            if (act.set_grp)   s_d.ctrl_rst  = {3{act.grp_val}};
        end
        load = enter;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, dev_rst_n: 2'b00, refclk_en: 1'b0,
                             ctrl_rst: 3'b000, done: 1'b0};
        else        s_q <= s_d;
    end

    assign dev_rst_n = s_q.dev_rst_n;
    assign refclk_en = s_q.refclk_en;
    assign ctrl_rst  = s_q.ctrl_rst;
    assign busy      = (s_q.phase != PH_IDLE);
    assign done      = s_q.done;
    assign clk_on    = s_q.refclk_en;
endmodule

// File: rtl/refclk_seq_checker.sv
module refclk_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       prepare_req,
    input logic       unprepare_req,
    input logic [1:0] dev_rst_n,
    input logic       refclk_en,
    input logic [2:0] ctrl_rst,
    input logic       busy,
    input logic       done,
    input logic       clk_on
);
    assert_group_uniform_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rst == 3'b000) || (ctrl_rst == 3'b111));

    assert_clk_rise_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refclk_en) |-> busy && (dev_rst_n == 2'b00));

    assert_release_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_rst_n[0]) |-> refclk_en && (ctrl_rst == 3'b000) && (dev_rst_n == 2'b11));

    assert_done_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy && refclk_en && (dev_rst_n == 2'b11) && (ctrl_rst == 3'b000));

    assert_idle_unprep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unprepare_req && !busy |=> !refclk_en && !done && $stable(dev_rst_n) && $stable(ctrl_rst));

    assert_status_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_on == refclk_en);

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        unprepare_req && busy |=> !busy && !refclk_en && !done);

    assert_unprep_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        prepare_req && unprepare_req |=> !busy);

    assert_busy_excl_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
endmodule

bind pcie_refclk_seq refclk_seq_checker u_chk (.*);

// File: tb/sim_pcie_refclk_seq.sv
module sim_pcie_refclk_seq;
    localparam int unsigned PERIOD  = 20;
    localparam int unsigned S_US    = 1;
    localparam int unsigned P_US    = 4;
    localparam int unsigned RC_US   = 2;
    localparam int unsigned RL_US   = 5;
    // R12: ceil(us*1000/period)
    localparam int N1   = (S_US * 1000 + PERIOD - 1) / PERIOD;
    localparam int N100 = (P_US * 1000 + PERIOD - 1) / PERIOD;
    localparam int N5   = (RC_US * 1000 + PERIOD - 1) / PERIOD;
    localparam int N250 = (RL_US * 1000 + PERIOD - 1) / PERIOD;
    localparam int T_GRP_OFF = 2 * N1;
    localparam int T_GRP_ON  = 3 * N1;
    localparam int T_GRP_END = 3 * N1 + N100;
    localparam int T_REL     = 4 * N1 + N100 + N5;
    localparam int T_DONE    = T_REL + N250;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prepare_req = 1'b0;
    logic unprepare_req = 1'b0;
    logic [1:0] dev_rst_n;
    logic refclk_en, busy, done, clk_on;
    logic [2:0] ctrl_rst;

    always #10 clk = ~clk;

    pcie_refclk_seq #(
        .CLK_PERIOD_NS(PERIOD), .SETTLE_US(S_US), .PULSE_US(P_US),
        .RECOVER_US(RC_US), .RELEASE_US(RL_US)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .prepare_req(prepare_req),
        .unprepare_req(unprepare_req), .dev_rst_n(dev_rst_n),
        .refclk_en(refclk_en), .ctrl_rst(ctrl_rst), .busy(busy),
        .done(done), .clk_on(clk_on)
    );

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int         exp_cyc[$];
    logic [8:0] exp_vec[$];
    string      exp_tag[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [8:0] mk(logic [1:0] p, logic r, logic [2:0] g, logic b, logic d);
        return {p, r, g, b, d, r};
    endfunction

    function automatic logic [8:0] now_vec();
        return {dev_rst_n, refclk_en, ctrl_rst, busy, done, clk_on};
    endfunction

    task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    task automatic push(int c, logic [8:0] v, string tag);
        exp_cyc.push_back(c);
        exp_vec.push_back(v);
        exp_tag.push_back(tag);
    endtask

    // Monitor: compares queued expectations when their cycle comes up.
    always @(negedge clk) begin
        while (exp_cyc.size() > 0 && exp_cyc[0] <= cyc) begin
            if (exp_cyc[0] == cyc) chk(exp_tag[0], now_vec(), exp_vec[0]);
            else chk({exp_tag[0], " (missed)"}, 9'h1FF, exp_vec[0]);
            void'(exp_cyc.pop_front());
            void'(exp_vec.pop_front());
            void'(exp_tag.pop_front());
        end
    end

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic pulse(logic p, logic u);
        prepare_req = p;
        unprepare_req = u;
        @(negedge clk);
        prepare_req = 1'b0;
        unprepare_req = 1'b0;
    endtask

    // Full run; grp0 is the reset-group value held before its own step.
    task automatic run_seq(logic [2:0] grp0, int mid_start);
        int b;
        b = cyc + 1;
        push(b,                mk(2'b00, 0, grp0,   1, 0), "R2");
        push(b + N1 - 1,       mk(2'b00, 0, grp0,   1, 0), "R2");
        push(b + N1,           mk(2'b00, 1, grp0,   1, 0), "R3");
        push(b + T_GRP_OFF,    mk(2'b00, 1, 3'b000, 1, 0), "R4");
        push(b + T_GRP_ON - 1, mk(2'b00, 1, 3'b000, 1, 0), "R4");
        push(b + T_GRP_ON,     mk(2'b00, 1, 3'b111, 1, 0), "R4");
        push(b + T_GRP_END - 1, mk(2'b00, 1, 3'b111, 1, 0), "R4");
        push(b + T_GRP_END,    mk(2'b00, 1, 3'b000, 1, 0), "R4");
        push(b + T_REL - 1,    mk(2'b00, 1, 3'b000, 1, 0), "R5");
        push(b + T_REL,        mk(2'b11, 1, 3'b000, 1, 0), "R5");
        push(b + T_DONE - 1,   mk(2'b11, 1, 3'b000, 1, 0), "R12");
        push(b + T_DONE,       mk(2'b11, 1, 3'b000, 0, 1), "R6");
        pulse(1'b1, 1'b0);
        if (mid_start >= 0) begin
            wait_until(b + mid_start - 1);
            pulse(1'b1, 1'b0);   // R9: ignored while busy
        end
        wait_until(b + T_DONE + 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : driver
        int b;
        repeat (3) @(negedge clk);
        chk("R1", now_vec(), mk(2'b00, 0, 3'b000, 0, 0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", now_vec(), mk(2'b00, 0, 3'b000, 0, 0));

        // From reset
        run_seq(3'b000, -1);
        // From finished state (clock on), with an ignored mid-run start
        run_seq(3'b000, 100);

        // R7: unprepare on a finished block
        push(cyc + 1, mk(2'b11, 0, 3'b000, 0, 0), "R7");
        pulse(1'b0, 1'b1);
        @(negedge clk);

        // R10: abort during the reset pulse
        b = cyc + 1;
        push(b + N1, mk(2'b00, 1, 3'b000, 1, 0), "R3");
        push(b + T_GRP_ON, mk(2'b00, 1, 3'b111, 1, 0), "R4");
        push(b + 200, mk(2'b00, 0, 3'b111, 0, 0), "R10");
        push(b + 201, mk(2'b00, 0, 3'b111, 0, 0), "R10");
        push(b + 202, mk(2'b00, 0, 3'b111, 0, 0), "R7");
        pulse(1'b1, 1'b0);
        wait_until(b + 199);
        pulse(1'b0, 1'b1);
        wait_until(b + 201);
        pulse(1'b0, 1'b1);     // idle unprepare keeps group asserted
        @(negedge clk);

        // Restart with group left asserted
        run_seq(3'b111, -1);

        // R11: coincident requests, unprepare wins
        push(cyc + 1, mk(2'b11, 0, 3'b000, 0, 0), "R11");
        push(cyc + 2, mk(2'b11, 0, 3'b000, 0, 0), "R11");
        pulse(1'b1, 1'b1);
        repeat (3) @(negedge clk);

        if (exp_cyc.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_cyc.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule